// File: doc/BRIEF.md
# Two-Channel External Pin Interrupt Controller

This block watches two external pins and turns activity on them into interrupt requests for a processor core. Each channel has a two-bit sense setting that selects low-level, any-edge, falling-edge or rising-edge detection. Edge events are caught in sticky flags. A low-level condition is never stored and requests only while the pin stays low. A memory-mapped mask register enables each channel. A global enable gates all requests. The block presents one request at a time to the core, together with the program address of the matching handler.

Software reaches two byte-wide registers over a simple bus: a mask register and a flag register. Flags are cleared by writing ones to them, or by the core's acknowledge when it takes a vector. The pins are used whatever their direction, so firmware can raise an interrupt by driving a pin configured as an output. Each pin passes through a two-flop synchroniser. Edges are found by comparing the synchronised sample with the sample one cycle older.

Top module: `pinIrqUnit`

## Requirements
- R1: After reset, the mask register, the flag register and `irqReq` are all zero, and `irqVector` reads 0.
- R2: In the mask register (address 0x3B), bit 7 enables channel 1 and bit 6 enables channel 0, and both read back as written. Mask bits 5..0 and flag bits 5..0 read as zero. Any other address reads as zero.
- R3: The sense setting `senseCtl[2i+1:2i]` of channel i works as follows: 01 sets the channel's flag on any edge, 10 on a falling edge, 11 on a rising edge. Flag bit 7 belongs to channel 1 and bit 6 to channel 0 (address 0x3A). An edge that does not match the setting leaves the flag clear.
- R4: With sense 00, the channel's flag is held at zero. The channel requests only while its synchronised pin is low, and stops requesting as soon as the pin is high.
- R5: A channel requests only when its mask bit and `globalEn` are both 1. A masked or globally disabled flag stays set but raises no request.
- R6: `irqVector` is 0x002 for channel 0 and 0x004 for channel 1. When both channels request, channel 0 is presented. Without a request, `irqVector` is 0.
- R7: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged.
- R8: A one-cycle pulse on `irqAck` clears only the flag of the channel being presented in that cycle. The other channel's request then comes forward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 6 | Register address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from address |
| pinIn | input | 2 | External pins, bit i is channel i |
| senseCtl | input | 4 | Sense setting, two bits per channel |
| globalEn | input | 1 | Global interrupt enable |
| irqReq | output | 1 | Interrupt request to the core |
| irqVector | output | 13 | Handler address of the presented channel |
| irqAck | input | 1 | Core has taken the presented vector |

## Verification
The hardest case to reach is an acknowledge while both channels hold flags. It has to clear only the presented flag, and the lower-priority channel has to come forward in the next cycle. The stimulus gets there by arming both channels for falling edges and dropping both pins together, so both flags are set in the same cycle. The bench then checks the vector, pulses the acknowledge, and reads the flag register and vector before the second acknowledge. A second hard case is a switch into level mode while flags are set. The bench checks that flag reads come back zero while the pin sits high.

// File: rtl/pinIrqPkg.sv
package pinIrqPkg;
  localparam int CH_COUNT = 2;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseT;

  // strobes from control to datapath
  typedef struct packed {
    logic                maskWr;
    logic [CH_COUNT-1:0] maskData;
    logic [CH_COUNT-1:0] flagClr;
    logic [CH_COUNT-1:0] ackClr;
  } ctrlStrobeT;
endpackage

// File: rtl/pinIrqPath.sv
module pinIrqPath
  import pinIrqPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int MASK_ADDR = 'h3B,
  parameter int FLAG_ADDR = 'h3A
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] pinIn,
  input  logic [2*CH_COUNT-1:0] senseCtl,
  input  ctrlStrobeT          strobe,
  input  logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   busRdata,
  output logic [CH_COUNT-1:0] chActive,
  output logic [CH_COUNT-1:0] maskBits
);
  localparam int LOW_BITS = DATA_W - CH_COUNT;

  logic [CH_COUNT-1:0] syncA, syncB, prevSample;
  logic [CH_COUNT-1:0] flagBits;
  logic [CH_COUNT-1:0] edgeHit;
  logic [CH_COUNT-1:0] levelMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA      <= '1;
      syncB      <= '1;
      prevSample <= '1;
    end else begin
      syncA      <= pinIn;
      syncB      <= syncA;
      prevSample <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskBits <= '0;
    else if (strobe.maskWr) maskBits <= strobe.maskData;
  end

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : gChan
    senseT mode;
    assign mode = senseT'(senseCtl[2*ch +: 2]);
    assign levelMode[ch] = (mode == SENSE_LOW);

    always_comb begin
      unique case (mode)
        SENSE_ANY:  edgeHit[ch] = syncB[ch] ^ prevSample[ch];
        SENSE_FALL: edgeHit[ch] = prevSample[ch] & ~syncB[ch];
        SENSE_RISE: edgeHit[ch] = ~prevSample[ch] & syncB[ch];
        default:    edgeHit[ch] = 1'b0;
      endcase
    end

    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagBits[ch] <= 1'b0;
      else if (levelMode[ch]) flagBits[ch] <= 1'b0;
      else if (edgeHit[ch]) flagBits[ch] <= 1'b1;
      else if (strobe.flagClr[ch] || strobe.ackClr[ch]) flagBits[ch] <= 1'b0;
    end

    assign chActive[ch] = levelMode[ch] ? ~syncB[ch] : flagBits[ch];
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(MASK_ADDR))
      busRdata = {maskBits, {LOW_BITS{1'b0}}};
    else if (busAddr == ADDR_W'(FLAG_ADDR))
      busRdata = {flagBits, {LOW_BITS{1'b0}}};
  end
endmodule

// File: rtl/pinIrqCtrl.sv
module pinIrqCtrl
  import pinIrqPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int VEC_W     = 13,
  parameter int VEC_STEP  = 2,
  parameter int MASK_ADDR = 'h3B,
  parameter int FLAG_ADDR = 'h3A
) (
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                globalEn,
  input  logic                irqAck,
  input  logic [CH_COUNT-1:0] chActive,
  input  logic [CH_COUNT-1:0] maskBits,
  output ctrlStrobeT          strobe,
  output logic                irqReq,
  output logic [VEC_W-1:0]    irqVector
);
  localparam int LOW_BITS = DATA_W - CH_COUNT;

  logic [CH_COUNT-1:0] pending, grant;

  assign pending = chActive & maskBits & {CH_COUNT{globalEn}};

  // lowest channel index has the lowest vector and wins
  always_comb begin
    grant     = '0;
    irqVector = '0;
    for (int ch = CH_COUNT - 1; ch >= 0; ch--) begin
      if (pending[ch]) begin
        grant     = '0;
        grant[ch] = 1'b1;
        irqVector = VEC_W'((ch + 1) * VEC_STEP);
      end
    end
  end

  assign irqReq = |pending;

  always_comb begin
    strobe.maskWr   = busWe && (busAddr == ADDR_W'(MASK_ADDR));
    strobe.maskData = busWdata[LOW_BITS +: CH_COUNT];
    strobe.flagClr  = (busWe && (busAddr == ADDR_W'(FLAG_ADDR)))
                      ? busWdata[LOW_BITS +: CH_COUNT] : '0;
    strobe.ackClr   = irqAck ? grant : '0;
  end
endmodule

// File: rtl/pinIrqUnit.sv
module pinIrqUnit
  import pinIrqPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int VEC_W     = 13,
  parameter int VEC_STEP  = 2,
  parameter int MASK_ADDR = 'h3B,
  parameter int FLAG_ADDR = 'h3A
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [CH_COUNT-1:0]   pinIn,
  input  logic [2*CH_COUNT-1:0] senseCtl,
  input  logic                  globalEn,
  output logic                  irqReq,
  output logic [VEC_W-1:0]      irqVector,
  input  logic                  irqAck
);
  ctrlStrobeT          strobe;
  logic [CH_COUNT-1:0] chActive, maskBits;

  pinIrqCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP),
    .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) uCtrl (
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .globalEn(globalEn), .irqAck(irqAck),
    .chActive(chActive), .maskBits(maskBits),
    .strobe(strobe), .irqReq(irqReq), .irqVector(irqVector)
  );

  pinIrqPath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) uPath (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .senseCtl(senseCtl),
    .strobe(strobe), .busAddr(busAddr), .busRdata(busRdata),
    .chActive(chActive), .maskBits(maskBits)
  );
endmodule

// File: rtl/pinIrqChecker.sv
module pinIrqChecker #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int VEC_W     = 13,
  parameter int MASK_ADDR = 'h3B,
  parameter int FLAG_ADDR = 'h3A
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic [3:0]        senseCtl,
  input logic              globalEn,
  input logic              irqReq,
  input logic [VEC_W-1:0]  irqVector
);
  AST_NO_REQ_WITHOUT_GIE: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !irqReq); // R5

  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector == VEC_W'(2) || irqVector == VEC_W'(4))); // R6

  AST_VECTOR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqVector == '0)); // R6

  AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(FLAG_ADDR) && senseCtl[1:0] == 2'b00
     && $past(senseCtl[1:0]) == 2'b00) |-> !busRdata[DATA_W-2]); // R4

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(FLAG_ADDR) || busAddr == ADDR_W'(MASK_ADDR))
    |-> (busRdata[DATA_W-3:0] == '0)); // R2
endmodule

bind pinIrqUnit pinIrqChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
  .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR)
) uChecker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdata(busRdata),
  .senseCtl(senseCtl), .globalEn(globalEn), .irqReq(irqReq),
  .irqVector(irqVector)
);

// File: tb/pinIrqUnit_test.sv
`timescale 1ns/1ps
module pinIrqUnit_test;
  localparam logic [5:0] MASK_A = 6'h3B;
  localparam logic [5:0] FLAG_A = 6'h3A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = MASK_A;
  logic        busWe = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [1:0]  pinIn = 2'b11;
  logic [3:0]  senseCtl = 4'b0000;
  logic        globalEn = 1'b0;
  logic        irqReq;
  logic [12:0] irqVector;
  logic        irqAck = 1'b0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pinIrqUnit uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .senseCtl(senseCtl), .globalEn(globalEn), .irqReq(irqReq),
    .irqVector(irqVector), .irqAck(irqAck)
  );

  typedef struct packed {
    logic [3:0]  sense;
    logic [1:0]  pinFrom;
    logic [1:0]  pinTo;
    logic [1:0]  mask;
    logic        gie;
    logic [7:0]  expFlag;
    logic        expReq;
    logic [12:0] expVec;
  } vecT;

  localparam int NV = 11;
  localparam vecT TABLE [NV] = '{
    '{4'b0101, 2'b00, 2'b01, 2'b11, 1'b1, 8'h40, 1'b1, 13'd2}, // R3 any edge
    '{4'b1111, 2'b11, 2'b00, 2'b11, 1'b1, 8'h00, 1'b0, 13'd0}, // R3 rise, fall seen
    '{4'b1010, 2'b11, 2'b00, 2'b11, 1'b1, 8'hC0, 1'b1, 13'd2}, // R6 priority
    '{4'b1010, 2'b11, 2'b01, 2'b11, 1'b1, 8'h80, 1'b1, 13'd4}, // R6 ch1 vector
    '{4'b1010, 2'b11, 2'b00, 2'b11, 1'b0, 8'hC0, 1'b0, 13'd0}, // R5 gie off
    '{4'b1010, 2'b11, 2'b00, 2'b10, 1'b1, 8'hC0, 1'b1, 13'd4}, // R5 ch0 masked
    '{4'b0000, 2'b11, 2'b01, 2'b11, 1'b1, 8'h00, 1'b1, 13'd4}, // R4 ch1 low
    '{4'b0000, 2'b11, 2'b11, 2'b11, 1'b1, 8'h00, 1'b0, 13'd0}, // R4 both high
    '{4'b0111, 2'b00, 2'b11, 2'b11, 1'b1, 8'hC0, 1'b1, 13'd2}, // R3 rise+any
    '{4'b0111, 2'b01, 2'b10, 2'b11, 1'b1, 8'h80, 1'b1, 13'd4}, // R3 mixed
    '{4'b0000, 2'b11, 2'b00, 2'b01, 1'b1, 8'h00, 1'b1, 13'd2}  // R4 ch0 only
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic ackPulse();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);

    // R1 reset state
    busRead(MASK_A, rd); check("R1 mask", rd, 8'h00);
    busRead(FLAG_A, rd); check("R1 flag", rd, 8'h00);
    check("R1 req", irqReq, 0);
    check("R1 vec", irqVector, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      senseCtl = TABLE[v].sense;
      globalEn = TABLE[v].gie;
      busWrite(MASK_A, {TABLE[v].mask, 6'b0});
      pinIn = TABLE[v].pinFrom;
      waitCycles(5);
      busWrite(FLAG_A, 8'hC0);
      pinIn = TABLE[v].pinTo;
      waitCycles(5);
      busRead(FLAG_A, rd);
      check($sformatf("R3/R4 flag vec%0d", v), rd, TABLE[v].expFlag);
      check($sformatf("R5 req vec%0d", v), irqReq, TABLE[v].expReq);
      check($sformatf("R6 vector vec%0d", v), irqVector, TABLE[v].expVec);
    end

    // R2 register layout
    busWrite(MASK_A, 8'hFF);
    busRead(MASK_A, rd); check("R2 mask readback", rd, 8'hC0);
    busRead(6'h10, rd); check("R2 unmapped", rd, 8'h00);
    busWrite(MASK_A, 8'h80);
    busRead(MASK_A, rd); check("R2 ch1 only", rd, 8'h80);
    busWrite(MASK_A, 8'hC0);

    // R7 write one to clear
    globalEn = 1'b1;
    senseCtl = 4'b1010;
    pinIn = 2'b11;
    waitCycles(5);
    busWrite(FLAG_A, 8'hC0);
    pinIn = 2'b00;
    waitCycles(5);
    busWrite(FLAG_A, 8'h00);
    busRead(FLAG_A, rd); check("R7 zero write keeps", rd, 8'hC0);
    busWrite(FLAG_A, 8'h40);
    busRead(FLAG_A, rd); check("R7 clear ch0", rd, 8'h80);
    check("R7 vector ch1", irqVector, 13'd4);

    // R8 acknowledge clears presented flag
    pinIn = 2'b11;
    waitCycles(5);
    busWrite(FLAG_A, 8'hC0);
    pinIn = 2'b00;
    waitCycles(5);
    check("R8 first vector", irqVector, 13'd2);
    ackPulse();
    busRead(FLAG_A, rd); check("R8 ack ch0", rd, 8'h80);
    check("R8 next vector", irqVector, 13'd4);
    ackPulse();
    busRead(FLAG_A, rd); check("R8 ack ch1", rd, 8'h00);
    check("R8 req idle", irqReq, 0);

    // R4 entering level mode drops held flags
    pinIn = 2'b11;
    waitCycles(5);
    pinIn = 2'b00;
    waitCycles(5);
    busRead(FLAG_A, rd); check("R4 flags armed", rd, 8'hC0);
    senseCtl = 4'b0000;
    pinIn = 2'b11;
    waitCycles(5);
    busRead(FLAG_A, rd); check("R4 level flag cleared", rd, 8'h00);
    check("R4 level high no req", irqReq, 0);
    pinIn = 2'b10;
    waitCycles(4);
    check("R4 level low req", irqReq, 1);
    pinIn = 2'b11;
    waitCycles(4);
    check("R4 released", irqReq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule